// File: doc/BRIEF.md
# Debug Register Access Front-End

This block is the side of an external debug module that faces the debugger. A debugger sends it requests over a valid/ready channel. Each request carries an address, a write value and an operation code. The block returns one response per request over a second valid/ready channel. The response carries the read value and a status code.

Behind the channel sits a small fixed register map:

- a data register shared with the abstract command engine,
- a control register whose bits drive the halt, resume and system-reset pins of the core,
- a read-only status word built from the run and halt inputs of the single hart,
- a hart-information word that reads as zero,
- the abstract status word, supplied by the command engine,
- the command register. Writes to it are forwarded to the engine as a one-cycle pulse.

Back-pressure follows these rules. The request side is ready whenever the single response slot is empty, or is being emptied in that same cycle. A request is accepted on a rising edge where valid and ready are both high. Its response appears in the slot from the next cycle. A response that is held back by a low response ready stays unchanged, and keeps request ready low, until it is taken. All register updates caused by a write take effect on the edge that accepts the write.

Top module: `dbg_regfront`

## Requirements
- R1: Request and response timing. A request is accepted when `req_valid` and `req_ready` are both high on a rising edge. `rsp_valid` rises on the following edge. There is exactly one response for each accepted request. After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: Response back-pressure. While `rsp_valid` is 1 and `rsp_ready` is 0, the response data and status stay unchanged and `req_ready` is 0.
- R3: Encodings. Operation codes are 0 = no-op, 1 = read and 2 = write. Status codes are 0 = success, 2 = failed and 3 = busy. A no-op returns success with data 0, and a write returns data 0.
- R4: Failed requests. A read or write to any address other than 0x04, 0x10, 0x11, 0x12, 0x16 or 0x17 returns failed with data 0. Operation code 3 returns failed.
- R5: Control register at 0x10. Bit 31 is the halt request, bit 30 the resume request, bit 1 the system reset and bit 0 the activation bit. Bits 29:2 read as 0. A write with bit 0 equal to 0 clears all four bits.
- R6: Inactive module. While the activation bit is 0, writes to 0x04 and 0x17 change nothing and send no command pulse, yet still return success.
- R7: Core control pins. `halt_req`, `resume_req` and `ndm_reset` equal control bits 31, 30 and 1. All three are 0 after reset.
- R8: Resume handshake. A set resume request clears on the edge where `resume_ack` is seen high. The halt request stays set until it is written to 0.
- R9: Status word at 0x11. Bits 11 and 10 equal `hart_running`, bits 9 and 8 equal `hart_halted`, and bits 3:0 read as 2. All other bits read as 0.
- R10: Other reads. 0x12 reads as 0. 0x16 reads as `abs_status`. 0x17 reads as 0.
- R11: Command forwarding. An accepted write to 0x17 while the module is active and the engine is idle raises `cmd_wr_valid` for exactly one cycle. The pulse starts with the response and carries the written value on `cmd_wr_data`.
- R12: Engine busy. While `abs_status` bit 12 is 1 and the module is active, a write to 0x04 or 0x17 returns busy and changes nothing. No command pulse is sent.
- R13: Data register at 0x04. It holds the last value written by the debugger or by the engine, and reads it back. A pulse on `eng_d0_valid` loads `eng_d0_data`. When both write in the same cycle, the engine write wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 32 | Register address |
| req_data | input | 32 | Write value |
| req_op | input | 2 | Operation code |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Debugger takes the response |
| rsp_data | output | 32 | Read value |
| rsp_status | output | 2 | Status code |
| halt_req | output | 1 | Ask the core to halt |
| resume_req | output | 1 | Ask the core to resume |
| resume_ack | input | 1 | Core confirms resume |
| ndm_reset | output | 1 | Reset the system outside the debug logic |
| hart_running | input | 1 | Hart is running |
| hart_halted | input | 1 | Hart is halted |
| abs_status | input | 32 | Abstract status word from the engine |
| cmd_wr_valid | output | 1 | Command write pulse to the engine |
| cmd_wr_data | output | 32 | Command value |
| data0 | output | 32 | Data register contents |
| eng_d0_valid | input | 1 | Engine writes the data register |
| eng_d0_data | input | 32 | Engine write value |

## Verification
The bench holds the response channel stalled while a response is pending. A slot that drops or changes its response would show as a missed or changed item. A slot that takes a second request would raise ready. The bench also drives resume and halt requests together and then pulses the acknowledge. A design that clears both bits, or neither, would leave the wrong pin levels. Further cases cover:
- writes made while the module is inactive, and writes made while the engine is busy, where a design that lets them through would change the data register or send a stray command pulse;
- unmapped addresses and the unused operation code, which would otherwise return success;
- a control write with the activation bit low, which would otherwise leave stale request bits set.

// File: rtl/dbg_regfront_pkg.sv
package dbg_regfront_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_RSVD  = 2'd3
  } req_op_e;

  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_RSVD = 2'd1,
    ST_FAIL = 2'd2,
    ST_BUSY = 2'd3
  } rsp_st_e;

  localparam int NREG = 6;
  localparam int DW   = 32;

  // index of each mapped register inside the hit vector
  localparam int IX_DATA0 = 0;
  localparam int IX_CTRL  = 1;
  localparam int IX_STAT  = 2;
  localparam int IX_INFO  = 3;
  localparam int IX_ABS   = 4;
  localparam int IX_CMD   = 5;

  function automatic logic [7:0] reg_addr(input int idx);
    case (idx)
      IX_DATA0: reg_addr = 8'h04;
      IX_CTRL:  reg_addr = 8'h10;
      IX_STAT:  reg_addr = 8'h11;
      IX_INFO:  reg_addr = 8'h12;
      IX_ABS:   reg_addr = 8'h16;
      default:  reg_addr = 8'h17;
    endcase
  endfunction

endpackage

// File: rtl/dbg_addr_decode.sv
module dbg_addr_decode
  import dbg_regfront_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]   addr,
  output logic [NREG-1:0] hit,
  output logic            mapped
);

  // one full-width comparator per mapped register
  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign hit[g] = (addr == AW'(reg_addr(g)));
  end

  assign mapped = |hit;

endmodule

// File: rtl/dbg_ctrl_state.sv
module dbg_ctrl_state
  import dbg_regfront_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic          d0_we,
  input  logic          cmd_we,
  input  logic [DW-1:0] wdata,
  input  logic          eng_d0_valid,
  input  logic [DW-1:0] eng_d0_data,
  input  logic          resume_ack,
  output logic          active_q,
  output logic          halt_q,
  output logic          resume_q,
  output logic          ndm_q,
  output logic [DW-1:0] data0_q,
  output logic          cmd_valid_q,
  output logic [DW-1:0] cmd_data_q
);

  localparam int B_HALT   = DW - 1;
  localparam int B_RESUME = DW - 2;
  localparam int B_NDM    = 1;
  localparam int B_ACT    = 0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      halt_q   <= 1'b0;
      resume_q <= 1'b0;
      ndm_q    <= 1'b0;
    end else if (ctrl_we) begin
      active_q <= wdata[B_ACT];
      halt_q   <= wdata[B_ACT] & wdata[B_HALT];
      resume_q <= wdata[B_ACT] & wdata[B_RESUME];
      ndm_q    <= wdata[B_ACT] & wdata[B_NDM];
    end else if (resume_q && resume_ack) begin
      resume_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data0_q <= '0;
    end else if (eng_d0_valid) begin
      data0_q <= eng_d0_data;
    end else if (d0_we) begin
      data0_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid_q <= 1'b0;
      cmd_data_q  <= '0;
    end else begin
      cmd_valid_q <= cmd_we;
      if (cmd_we) cmd_data_q <= wdata;
    end
  end

  // R5
  inactive_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (!halt_q && !resume_q && !ndm_q));

  // R8
  resume_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_q && resume_ack && !ctrl_we) |=> !resume_q);

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !ctrl_we) |=> halt_q);

  // R11
  cmd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_q && !cmd_we) |=> !cmd_valid_q);

endmodule

// File: rtl/dbg_rsp_slot.sv
module dbg_rsp_slot
  import dbg_regfront_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic [1:0]    load_status,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [1:0]    rsp_status,
  output logic          can_accept
);

  assign can_accept = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_status <= ST_OK;
    end else if (load) begin
      rsp_valid  <= 1'b1;
      rsp_data   <= load_data;
      rsp_status <= load_status;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  // R2
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_status)));

  // R1
  load_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rsp_valid);

endmodule

// File: rtl/dbg_regfront.sv
module dbg_regfront
  import dbg_regfront_pkg::*;
#(
  parameter int         AW       = 32,
  parameter logic [3:0] VERSION  = 4'd2,
  parameter int         BUSY_BIT = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_data,
  input  logic [1:0]    req_op,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [31:0]   rsp_data,
  output logic [1:0]    rsp_status,
  output logic          halt_req,
  output logic          resume_req,
  input  logic          resume_ack,
  output logic          ndm_reset,
  input  logic          hart_running,
  input  logic          hart_halted,
  input  logic [31:0]   abs_status,
  output logic          cmd_wr_valid,
  output logic [31:0]   cmd_wr_data,
  output logic [31:0]   data0,
  input  logic          eng_d0_valid,
  input  logic [31:0]   eng_d0_data
);

  logic [NREG-1:0] hit;
  logic            mapped;
  logic            accept;
  logic            active;
  logic            abs_busy;
  logic            eng_target;
  logic            ctrl_we, d0_we, cmd_we;
  logic [DW-1:0]   rd_val;
  logic [DW-1:0]   rsp_d_next;
  logic [1:0]      rsp_s_next;
  req_op_e         op;

  assign op       = req_op_e'(req_op);
  assign accept   = req_valid && req_ready;
  assign abs_busy = abs_status[BUSY_BIT];
  assign eng_target = hit[IX_DATA0] || hit[IX_CMD];

  dbg_addr_decode #(.AW(AW)) u_dec (
    .addr   (req_addr),
    .hit    (hit),
    .mapped (mapped)
  );

  // write strobes: control always, engine-facing ones only when active and idle
  assign ctrl_we = accept && (op == OP_WRITE) && hit[IX_CTRL];
  assign d0_we   = accept && (op == OP_WRITE) && hit[IX_DATA0] && active && !abs_busy;
  assign cmd_we  = accept && (op == OP_WRITE) && hit[IX_CMD]   && active && !abs_busy;

  dbg_ctrl_state u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_we      (ctrl_we),
    .d0_we        (d0_we),
    .cmd_we       (cmd_we),
    .wdata        (req_data),
    .eng_d0_valid (eng_d0_valid),
    .eng_d0_data  (eng_d0_data),
    .resume_ack   (resume_ack),
    .active_q     (active),
    .halt_q       (halt_req),
    .resume_q     (resume_req),
    .ndm_q        (ndm_reset),
    .data0_q      (data0),
    .cmd_valid_q  (cmd_wr_valid),
    .cmd_data_q   (cmd_wr_data)
  );

  // read multiplexer
  always_comb begin
    rd_val = '0;
    if (hit[IX_DATA0]) rd_val = data0;
    if (hit[IX_CTRL])  rd_val = {halt_req, resume_req, 28'd0, ndm_reset, active};
    if (hit[IX_STAT])  rd_val = {20'd0, hart_running, hart_running,
                                 hart_halted, hart_halted, 4'd0, VERSION};
    if (hit[IX_ABS])   rd_val = abs_status;
  end

  // response content
  always_comb begin
    rsp_d_next = '0;
    rsp_s_next = ST_OK;
    case (op)
      OP_NOP: ;
      OP_READ: begin
        if (!mapped) rsp_s_next = ST_FAIL;
        else         rsp_d_next = rd_val;
      end
      OP_WRITE: begin
        if (!mapped)                           rsp_s_next = ST_FAIL;
        else if (active && abs_busy && eng_target) rsp_s_next = ST_BUSY;
      end
      default: rsp_s_next = ST_FAIL;
    endcase
  end

  dbg_rsp_slot u_slot (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept),
    .load_data   (rsp_d_next),
    .load_status (rsp_s_next),
    .rsp_ready   (rsp_ready),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .rsp_status  (rsp_status),
    .can_accept  (req_ready)
  );

  // R1
  stall_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R11
  cmd_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_valid |-> rsp_valid);

  // R12
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_WRITE && eng_target && active && abs_busy)
      |=> (rsp_status == ST_BUSY && !cmd_wr_valid));

  // R4
  unmapped_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !mapped && op != OP_NOP) |=> (rsp_status == ST_FAIL && rsp_data == '0));

endmodule

// File: tb/dbg_regfront_test.sv
`timescale 1ns/1ps
module dbg_regfront_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic [1:0]  req_op = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;
  logic [1:0]  rsp_status;
  logic        halt_req, resume_req, ndm_reset;
  logic        resume_ack = 1'b0;
  logic        hart_running = 1'b0;
  logic        hart_halted = 1'b0;
  logic [31:0] abs_status = '0;
  logic        cmd_wr_valid;
  logic [31:0] cmd_wr_data;
  logic [31:0] data0;
  logic        eng_d0_valid = 1'b0;
  logic [31:0] eng_d0_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit stall = 0;
  int cmd_count = 0;
  logic [31:0] cmd_last = '0;

  logic [31:0] q_data[$];
  logic [1:0]  q_stat[$];
  string       q_tag[$];

  dbg_regfront uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_data(req_data), .req_op(req_op),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_status(rsp_status),
    .halt_req(halt_req), .resume_req(resume_req), .resume_ack(resume_ack),
    .ndm_reset(ndm_reset), .hart_running(hart_running), .hart_halted(hart_halted),
    .abs_status(abs_status), .cmd_wr_valid(cmd_wr_valid), .cmd_wr_data(cmd_wr_data),
    .data0(data0), .eng_d0_valid(eng_d0_valid), .eng_d0_data(eng_d0_data)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    #1 rsp_ready <= rst_n && !stall;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare each taken response against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_wr_valid) begin
        cmd_count++;
        cmd_last = cmd_wr_data;
      end
      if (rsp_valid && rsp_ready) begin
        if (q_data.size() == 0) begin
          check("R1 unexpected response", 32'd1, 32'd0);
        end else begin
          automatic logic [31:0] ed = q_data.pop_front();
          automatic logic [1:0]  es = q_stat.pop_front();
          automatic string       t  = q_tag.pop_front();
          check({t, " data"}, rsp_data, ed);
          check({t, " status"}, {30'd0, rsp_status}, {30'd0, es});
        end
      end
    end
  end

  task automatic send(input logic [31:0] a, input logic [31:0] d, input logic [1:0] op,
                      input logic [31:0] ed, input logic [1:0] es, input string tag);
    q_data.push_back(ed);
    q_stat.push_back(es);
    q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_data  = d;
    req_op    = op;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q_data.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  localparam logic [1:0] NOP = 2'd0, RD = 2'd1, WR = 2'd2;
  localparam logic [1:0] OK = 2'd0, FL = 2'd2, BZ = 2'd3;

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    int c0;
    repeat (3) @(negedge clk);
    // R1 R7 reset state
    check("R1 reset req_ready", {31'd0, req_ready}, 32'd1);
    check("R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R7 reset pins", {29'd0, halt_req, resume_req, ndm_reset}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 no-op
    send(32'h10, 32'hFFFF_FFFF, NOP, 32'd0, OK, "R3 nop");
    // R5 control reads zero
    send(32'h10, 0, RD, 32'd0, OK, "R5 ctrl reset read");
    // R6 inactive: data0 write ignored, command write ignored
    send(32'h04, 32'hDEAD_BEEF, WR, 32'd0, OK, "R6 inactive d0 write");
    send(32'h04, 0, RD, 32'd0, OK, "R6 inactive d0 read");
    send(32'h17, 32'h0000_1111, WR, 32'd0, OK, "R6 inactive cmd write");
    drain();
    check("R6 no cmd pulse", cmd_count, 0);

    // R5 R7 full write
    send(32'h10, 32'hFFFF_FFFF, WR, 32'd0, OK, "R5 ctrl write");
    send(32'h10, 0, RD, 32'hC000_0003, OK, "R5 ctrl read masked");
    drain();
    check("R7 pins set", {29'd0, halt_req, resume_req, ndm_reset}, 32'd7);

    // R8 resume ack clears only resume
    send(32'h10, 32'hC000_0001, WR, 32'd0, OK, "R8 ctrl write");
    drain();
    check("R8 before ack", {30'd0, halt_req, resume_req}, 32'd3);
    resume_ack = 1'b1;
    @(negedge clk);
    resume_ack = 1'b0;
    @(negedge clk);
    check("R8 after ack", {30'd0, halt_req, resume_req}, 32'd2);
    send(32'h10, 0, RD, 32'h8000_0001, OK, "R8 ctrl read after ack");

    // R5 deactivate clears everything
    send(32'h10, 32'hC000_0002, WR, 32'd0, OK, "R5 deactivate");
    send(32'h10, 0, RD, 32'd0, OK, "R5 read after deactivate");
    drain();
    check("R7 pins cleared", {29'd0, halt_req, resume_req, ndm_reset}, 32'd0);
    send(32'h10, 32'h0000_0001, WR, 32'd0, OK, "R5 activate");

    // R13 data register
    send(32'h04, 32'h1234_5678, WR, 32'd0, OK, "R13 d0 write");
    send(32'h04, 0, RD, 32'h1234_5678, OK, "R13 d0 read");

    // R9 status word
    hart_running = 1'b1; hart_halted = 1'b0;
    send(32'h11, 0, RD, 32'h0000_0C02, OK, "R9 running");
    drain();
    hart_running = 1'b0; hart_halted = 1'b1;
    send(32'h11, 0, RD, 32'h0000_0302, OK, "R9 halted");

    // R10 other reads
    send(32'h12, 0, RD, 32'd0, OK, "R10 info");
    drain();
    abs_status = 32'h0000_0300;
    send(32'h16, 0, RD, 32'h0000_0300, OK, "R10 abs status");
    send(32'h17, 0, RD, 32'd0, OK, "R10 cmd read");

    // R4 failures
    send(32'h20, 0, RD, 32'd0, FL, "R4 unmapped read");
    send(32'h0000_0104, 32'h5, WR, 32'd0, FL, "R4 unmapped write");
    send(32'h04, 0, 2'd3, 32'd0, FL, "R4 op3");
    send(32'h04, 0, RD, 32'h1234_5678, OK, "R4 d0 untouched");

    // R11 command forwarding
    drain();
    c0 = cmd_count;
    send(32'h17, 32'h0002_100A, WR, 32'd0, OK, "R11 cmd write");
    drain();
    check("R11 pulse count", cmd_count, c0 + 1);
    check("R11 pulse data", cmd_last, 32'h0002_100A);

    // R12 busy engine
    abs_status = 32'h0000_1000;
    c0 = cmd_count;
    send(32'h17, 32'h0000_1001, WR, 32'd0, BZ, "R12 busy cmd");
    send(32'h04, 32'hAAAA_5555, WR, 32'd0, BZ, "R12 busy d0");
    send(32'h04, 0, RD, 32'h1234_5678, OK, "R12 d0 unchanged");
    send(32'h11, 0, RD, 32'h0000_0302, OK, "R12 status read while busy");
    drain();
    check("R12 no pulse", cmd_count, c0);
    abs_status = 32'd0;

    // R13 engine write
    @(negedge clk);
    eng_d0_valid = 1'b1; eng_d0_data = 32'h0BAD_F00D;
    @(negedge clk);
    eng_d0_valid = 1'b0;
    send(32'h04, 0, RD, 32'h0BAD_F00D, OK, "R13 engine write");
    drain();

    // R2 back-pressure
    stall = 1;
    @(negedge clk);
    @(negedge clk);
    send(32'h11, 0, RD, 32'h0000_0302, OK, "R2 stalled read");
    @(negedge clk);
    check("R2 rsp valid", {31'd0, rsp_valid}, 32'd1);
    check("R2 req blocked", {31'd0, req_ready}, 32'd0);
    held = rsp_data;
    repeat (3) @(negedge clk);
    check("R2 data held", rsp_data, held);
    check("R2 still valid", {31'd0, rsp_valid}, 32'd1);
    stall = 0;
    drain();
    check("R1 one response", q_data.size(), 0);
    check("R1 slot empty", {31'd0, rsp_valid}, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule